// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves data between two 18-bit buses, A and B. Each direction has its own set of three controls: an active-low output enable, a latch enable and a direction clock. With these controls one direction can pass data straight through, hold the last value, or capture a new value on a rising edge of its direction clock. The 18 bits can work as one wide path or as two 9-bit halves, and each half can have its own controls. A parameter picks whether the upper half obeys its own controls or follows the lower half's. Each bus appears as three vectors: input, output and output enable. There are no tri-state pins. A deasserted output-enable vector stands for a high-impedance bus.

Each direction stores data in a single element that acts as both latch and flip-flop, and a fast system clock writes it on every cycle. The element takes the input while the latch enable is high. It also takes the input in the system cycle in which the direction clock is first seen high after having been low. In every other cycle it keeps its value. The direction clock is sampled synchronously, and a one-cycle history register detects its rising edge. While the test-mode input is high, the functional path is switched off.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's latch enable is high and test mode is low, its output bits equal its input bits in the same cycle. The value present at the next system clock edge is stored.
- R2: While the latch enable is low and no rising direction-clock edge is detected, the output keeps showing the stored value and ignores changes on the input.
- R3: With the latch enable low, a rising edge of the direction clock stores the input at the system clock edge where the direction clock is sampled high after being sampled low. Keeping the direction clock high stores nothing more.
- R4: The output-enable vector of a direction is all ones in the cycle after its active-low enable is sampled low, and all zeros in the cycle after it is sampled high.
- R5: The B-to-A direction behaves as in R1 to R4, using its own controls. It drives the A-side output and A-side enable from the B input.
- R6: With SPLIT_HALVES=1, bits [8:0] obey control index 0 and bits [17:9] obey control index 1, independently of each other.
- R7: With SPLIT_HALVES=0, both halves obey control index 0, and the index 1 controls have no effect.
- R8: While test mode is high, both output-enable vectors are zero from the next edge on. Nothing is stored, even on a latch enable or a rising edge, and the outputs show the stored value instead of passing the input through.
- R9: Reset clears both stored values, both output-enable vectors and the direction-clock history to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the direction clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | High to inhibit the functional path |
| a_in_i | input | 18 | Data arriving on the A bus |
| a_out_o | output | 18 | Data driven onto the A bus (B-to-A path) |
| a_oe_o | output | 18 | A-bus drive enable, 1 = driving |
| b_in_i | input | 18 | Data arriving on the B bus |
| b_out_o | output | 18 | Data driven onto the B bus (A-to-B path) |
| b_oe_o | output | 18 | B-bus drive enable, 1 = driving |
| ab_oe_n_i | input | 2 | A-to-B output enable, active low, one per half |
| ab_le_i | input | 2 | A-to-B latch enable, one per half |
| ab_clk_i | input | 2 | A-to-B direction clock, one per half |
| ba_oe_n_i | input | 2 | B-to-A output enable, active low, one per half |
| ba_le_i | input | 2 | B-to-A latch enable, one per half |
| ba_clk_i | input | 2 | B-to-A direction clock, one per half |

## Verification
The bench drives the direction clock high for several system cycles. A design that detected levels instead of edges would keep reloading, and the held value would then follow the input. It places a store in one half and a hold in the other. A design that shared the controls by mistake would change both halves, and the shared-control instance would wrongly obey the upper controls. In test mode it raises both latch enable and a direction-clock edge. A design that gated only the enables would pass the new data through or store it, which the bench sees once test mode is released.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Controls of one transfer direction
    typedef struct packed {
        logic oe_n;   // active-low output enable
        logic le;     // latch enable (transparent when high)
        logic dclk;   // direction clock, sampled by the system clock
    } dir_ctrl_t;

    // Controls of one half, both directions
    typedef struct packed {
        dir_ctrl_t ab;
        dir_ctrl_t ba;
    } half_ctrl_t;

endpackage

// File: rtl/ubt_ctrl_sel.sv
module ubt_ctrl_sel
    import ubt_pkg::*;
#(
    parameter int HALVES       = 2,
    parameter bit SPLIT_HALVES = 1'b1
) (
    input  logic [HALVES-1:0]             ab_oe_n_i,
    input  logic [HALVES-1:0]             ab_le_i,
    input  logic [HALVES-1:0]             ab_clk_i,
    input  logic [HALVES-1:0]             ba_oe_n_i,
    input  logic [HALVES-1:0]             ba_le_i,
    input  logic [HALVES-1:0]             ba_clk_i,
    output half_ctrl_t [HALVES-1:0]       ctrl_o
);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        // Shared mode steers every half to index 0
        localparam int SRC = SPLIT_HALVES ? h : 0;

        assign ctrl_o[h].ab.oe_n = ab_oe_n_i[SRC];
        assign ctrl_o[h].ab.le   = ab_le_i[SRC];
        assign ctrl_o[h].ab.dclk = ab_clk_i[SRC];
        assign ctrl_o[h].ba.oe_n = ba_oe_n_i[SRC];
        assign ctrl_o[h].ba.le   = ba_le_i[SRC];
        assign ctrl_o[h].ba.dclk = ba_clk_i[SRC];
    end

endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
    import ubt_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         test_i,
    input  dir_ctrl_t    ctrl_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic [W-1:0] oe_o
);

    typedef struct packed {
        logic [W-1:0] store;     // merged latch / flip-flop content
        logic         clk_seen;  // direction clock at the previous edge
        logic         oe;        // registered drive enable
    } path_st_t;

    path_st_t st_d, st_q;
    logic     rise;
    logic     load;
    logic     pass;

    always_comb begin
        st_d          = st_q;
        rise          = ctrl_i.dclk & ~st_q.clk_seen;
        load          = ~test_i & (ctrl_i.le | rise);
        pass          = ~test_i & ctrl_i.le;
        st_d.clk_seen = ctrl_i.dclk;
        st_d.oe       = ~test_i & ~ctrl_i.oe_n;
        if (load) begin
            st_d.store = din_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = pass ? din_i : st_q.store;
    assign oe_o   = {W{st_q.oe}};

endmodule

// File: rtl/ubt_half.sv
module ubt_half
    import ubt_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         test_i,
    input  half_ctrl_t   ctrl_i,
    input  logic [W-1:0] a_in_i,
    output logic [W-1:0] a_out_o,
    output logic [W-1:0] a_oe_o,
    input  logic [W-1:0] b_in_i,
    output logic [W-1:0] b_out_o,
    output logic [W-1:0] b_oe_o
);

    ubt_dir_path #(.W(W)) ab_path_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .test_i (test_i),
        .ctrl_i (ctrl_i.ab),
        .din_i  (a_in_i),
        .dout_o (b_out_o),
        .oe_o   (b_oe_o)
    );

    ubt_dir_path #(.W(W)) ba_path_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .test_i (test_i),
        .ctrl_i (ctrl_i.ba),
        .din_i  (b_in_i),
        .dout_o (a_out_o),
        .oe_o   (a_oe_o)
    );

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int HALF_W       = 9,
    parameter int HALVES       = 2,
    parameter bit SPLIT_HALVES = 1'b1,
    localparam int BUS_W       = HALF_W * HALVES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_mode_i,
    input  logic [BUS_W-1:0]  a_in_i,
    output logic [BUS_W-1:0]  a_out_o,
    output logic [BUS_W-1:0]  a_oe_o,
    input  logic [BUS_W-1:0]  b_in_i,
    output logic [BUS_W-1:0]  b_out_o,
    output logic [BUS_W-1:0]  b_oe_o,
    input  logic [HALVES-1:0] ab_oe_n_i,
    input  logic [HALVES-1:0] ab_le_i,
    input  logic [HALVES-1:0] ab_clk_i,
    input  logic [HALVES-1:0] ba_oe_n_i,
    input  logic [HALVES-1:0] ba_le_i,
    input  logic [HALVES-1:0] ba_clk_i
);

    half_ctrl_t [HALVES-1:0] half_ctrl;

    ubt_ctrl_sel #(
        .HALVES       (HALVES),
        .SPLIT_HALVES (SPLIT_HALVES)
    ) ctrl_sel_i (
        .ab_oe_n_i (ab_oe_n_i),
        .ab_le_i   (ab_le_i),
        .ab_clk_i  (ab_clk_i),
        .ba_oe_n_i (ba_oe_n_i),
        .ba_le_i   (ba_le_i),
        .ba_clk_i  (ba_clk_i),
        .ctrl_o    (half_ctrl)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_slice
        localparam int LO = h * HALF_W;

        ubt_half #(.W(HALF_W)) half_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .test_i  (test_mode_i),
            .ctrl_i  (half_ctrl[h]),
            .a_in_i  (a_in_i[LO +: HALF_W]),
            .a_out_o (a_out_o[LO +: HALF_W]),
            .a_oe_o  (a_oe_o[LO +: HALF_W]),
            .b_in_i  (b_in_i[LO +: HALF_W]),
            .b_out_o (b_out_o[LO +: HALF_W]),
            .b_oe_o  (b_oe_o[LO +: HALF_W])
        );
    end

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int BUS_W = HALF_W * HALVES
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              test_mode_i,
    input logic [BUS_W-1:0]  a_in_i,
    input logic [BUS_W-1:0]  a_out_o,
    input logic [BUS_W-1:0]  a_oe_o,
    input logic [BUS_W-1:0]  b_in_i,
    input logic [BUS_W-1:0]  b_out_o,
    input logic [BUS_W-1:0]  b_oe_o,
    input logic [HALVES-1:0] ab_oe_n_i,
    input logic [HALVES-1:0] ab_le_i,
    input logic [HALVES-1:0] ab_clk_i,
    input logic [HALVES-1:0] ba_oe_n_i,
    input logic [HALVES-1:0] ba_le_i,
    input logic [HALVES-1:0] ba_clk_i
);

    // R9
    rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (a_oe_o == '0 && b_oe_o == '0));

    // R4
    ab_oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_mode_i && !ab_oe_n_i[0]) |=> (&b_oe_o[HALF_W-1:0]));

    // R4
    ab_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ab_oe_n_i[0] |=> (b_oe_o[HALF_W-1:0] == '0));

    // R8
    test_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_mode_i |=> (a_oe_o == '0 && b_oe_o == '0));

    // R8
    test_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_mode_i && $past(test_mode_i)) |-> ($stable(a_out_o) && $stable(b_out_o)));

    // R1
    ab_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_mode_i && ab_le_i[0]) |=>
        (ab_le_i[0] || b_out_o[HALF_W-1:0] == $past(a_in_i[HALF_W-1:0])));

    // R3
    ab_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_mode_i && !ab_le_i[0] && ab_clk_i[0] && !$past(ab_clk_i[0])) |=>
        (ab_le_i[0] || b_out_o[HALF_W-1:0] == $past(a_in_i[HALF_W-1:0])));

    // R5
    ba_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_mode_i && !ba_le_i[0] && ba_clk_i[0] && !$past(ba_clk_i[0])) |=>
        (ba_le_i[0] || a_out_o[HALF_W-1:0] == $past(b_in_i[HALF_W-1:0])));

    // R5
    ba_oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_mode_i && !ba_oe_n_i[0]) |=> (&a_oe_o[HALF_W-1:0]));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(
    .HALF_W (HALF_W),
    .HALVES (HALVES)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_mode_i (test_mode_i),
    .a_in_i      (a_in_i),
    .a_out_o     (a_out_o),
    .a_oe_o      (a_oe_o),
    .b_in_i      (b_in_i),
    .b_out_o     (b_out_o),
    .b_oe_o      (b_oe_o),
    .ab_oe_n_i   (ab_oe_n_i),
    .ab_le_i     (ab_le_i),
    .ab_clk_i    (ab_clk_i),
    .ba_oe_n_i   (ba_oe_n_i),
    .ba_le_i     (ba_le_i),
    .ba_clk_i    (ba_clk_i)
);

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/1ps
module ubt_xcvr_tb_top;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [1:0]   ab_oe_n = 2'b11, ab_le = 2'b00, ab_clk = 2'b00;
    logic [1:0]   ba_oe_n = 2'b11, ba_le = 2'b00, ba_clk = 2'b00;

    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic [W-1:0] sa_out, sa_oe, sb_out, sb_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ubt_xcvr #(.SPLIT_HALVES(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode),
        .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
        .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe),
        .ab_oe_n_i(ab_oe_n), .ab_le_i(ab_le), .ab_clk_i(ab_clk),
        .ba_oe_n_i(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk)
    );

    ubt_xcvr #(.SPLIT_HALVES(1'b0)) dut_sh_i (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode),
        .a_in_i(a_in), .a_out_o(sa_out), .a_oe_o(sa_oe),
        .b_in_i(b_in), .b_out_o(sb_out), .b_oe_o(sb_oe),
        .ab_oe_n_i(ab_oe_n), .ab_le_i(ab_le), .ab_clk_i(ab_clk),
        .ba_oe_n_i(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk)
    );

    // {le, dclk, oe_n, data[17:0], expected out[17:0], expected oe}
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 18'h12345, 18'h12345, 1'b1},
        {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h12345, 1'b1},
        {1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF, 1'b1},
        {1'b0, 1'b1, 1'b0, 18'h00AAA, 18'h3FFFF, 1'b1},
        {1'b0, 1'b0, 1'b0, 18'h00AAA, 18'h3FFFF, 1'b1},
        {1'b0, 1'b1, 1'b0, 18'h15555, 18'h15555, 1'b1},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h15555, 1'b0},
        {1'b1, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1}
    };

    function automatic string vec_tag(input int i, input int dir);
        string t;
        case (i)
            0, 7:    t = "R1";
            1, 3, 4: t = "R2";
            2, 5:    t = "R3";
            default: t = "R4";
        endcase
        return dir ? {"R5/", t} : t;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one system clock and settle away from the edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        // R9 reset state
        check("R9 b_oe", b_oe, '0);
        check("R9 a_oe", a_oe, '0);
        check("R9 b_out", b_out, '0);
        check("R9 a_out", a_out, '0);

        // table walk: pass 0 = A to B, pass 1 = B to A
        for (int dir = 0; dir < 2; dir++) begin
            for (int i = 0; i < NV; i++) begin
                logic le, dc, on;
                logic [W-1:0] dat, eo;
                logic eoe;
                {le, dc, on, dat, eo, eoe} = VEC[i];
                if (dir == 0) begin
                    ab_le = {2{le}}; ab_clk = {2{dc}}; ab_oe_n = {2{on}}; a_in = dat;
                end else begin
                    ba_le = {2{le}}; ba_clk = {2{dc}}; ba_oe_n = {2{on}}; b_in = dat;
                end
                step();
                if (dir == 0) begin
                    check(vec_tag(i, dir), b_out, eo);
                    check(vec_tag(i, dir), b_oe, {W{eoe}});
                    check(vec_tag(i, dir), sb_out, eo);
                end else begin
                    check(vec_tag(i, dir), a_out, eo);
                    check(vec_tag(i, dir), a_oe, {W{eoe}});
                    check(vec_tag(i, dir), sa_out, eo);
                end
            end
            if (dir == 0) begin
                ab_le = 2'b00; ab_clk = 2'b00; ab_oe_n = 2'b11;
            end else begin
                ba_le = 2'b00; ba_clk = 2'b00; ba_oe_n = 2'b11;
            end
            step();
        end

        // R6 / R7: lower half transparent and driving, upper half held and off
        ab_le = 2'b01; ab_clk = 2'b00; ab_oe_n = 2'b10; a_in = 18'h3FFFF;
        step();
        check("R6 split out", b_out, 18'h2ABFF);
        check("R6 split oe", b_oe, 18'h001FF);
        check("R7 shared out", sb_out, 18'h3FFFF);
        check("R7 shared oe", sb_oe, 18'h3FFFF);

        // R6 / R7: rising edge on the upper direction clock only
        ab_le = 2'b00; ab_clk = 2'b10; ab_oe_n = 2'b00; a_in = 18'h00000;
        step();
        check("R6 upper capture", b_out, 18'h001FF);
        check("R7 upper clock ignored", sb_out, 18'h3FFFF);
        ab_clk = 2'b00;
        step();

        // R8: test mode blocks pass-through, storage and drive
        test_mode = 1'b1;
        ab_le = 2'b11; ab_clk = 2'b11; ab_oe_n = 2'b00; a_in = 18'h0F0F0;
        ba_le = 2'b11; ba_oe_n = 2'b00; b_in = 18'h0F0F0;
        step();
        check("R8 b_oe off", b_oe, '0);
        check("R8 a_oe off", a_oe, '0);
        check("R8 no pass", b_out, 18'h001FF);
        check("R8 no pass shared", sb_out, 18'h3FFFF);

        // leave test mode with stores closed: stored value must be the old one
        test_mode = 1'b0;
        ab_le = 2'b00; ba_le = 2'b00;
        step();
        check("R8 store kept", b_out, 18'h001FF);
        check("R8 store kept shared", sb_out, 18'h3FFFF);
        check("R8 store kept b2a", a_out, 18'h2AAAA);
        check("R4 oe back", b_oe, 18'h3FFFF);

        finish_run();
    end

endmodule